// File: doc/BRIEF.md
# Two-Level Page-Table Walker

This block resolves a virtual-to-physical translation after the translation buffer has missed. The virtual address is 32 bits wide. The page tables have two levels and sit in physical memory, so the walker reads them with physical addresses and never translates its own reads. When the walker accepts a miss, it captures the faulting virtual address and the current process's root pointer. It then reads the directory entry and, from the table that entry points to, the leaf entry. The walk ends in one of two ways: a refill carrying the physical page number and the permission bits, or a precise fault. The fault names the level that failed and holds the virtual address until software acknowledges it.

Memory is reached through a request/response port. A request is held until `mem_req_ready` is high. The response may arrive any number of cycles later. A successful walk makes exactly two reads. A walk that stops at the directory level makes one read.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is held low, and on the cycle after it is released, `busy`, `mem_req_valid`, `refill_valid` and `fault_valid` are all 0.
- R2: A miss is accepted only when the walker is idle and `miss_valid` is 1. On acceptance the walker captures `miss_vaddr` and `root_ptr`, so later changes to those inputs do not affect the walk. `busy` is 1 from the next cycle until the walker returns to idle. `miss_valid` is ignored while `busy` is 1.
- R3: The first read uses address {root_ptr[31:12], 12'h000} + vaddr[31:22]*4. `mem_req_valid` and `mem_req_addr` stay unchanged until a cycle where `mem_req_ready` is 1.
- R4: Each table entry uses this layout: bit 0 is valid, bit 1 is resident, bits 4:2 are the permissions, and bits 31:12 are a page number. An entry is usable when bits 0 and 1 are both 1. If the directory entry is usable, the second read uses address {entry[31:12], 12'h000} + vaddr[21:12]*4.
- R5: If the leaf entry is usable, `refill_valid` is high for exactly one cycle. In that cycle `refill_ppn` = entry[31:12], `refill_perm` = entry[4:2] and `refill_vpn` = vaddr[31:12]. The walker is idle on the following cycle.
- R6: An unusable directory entry gives a fault with `fault_level` = 0. An unusable leaf entry gives a fault with `fault_level` = 1. `fault_valid`, `fault_level` and `fault_vaddr` (the captured address) hold until a cycle where `fault_ack` is 1. The walker is idle on the cycle after that.
- R7: `mem_resp_valid` is ignored when no read is outstanding. `fault_ack` is ignored when no fault is being reported. `mem_req_valid` is never 1 while the walker is idle.
- R8: A successful walk, or one ending in a leaf fault, makes exactly two memory reads. A walk ending in a directory fault makes exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_ptr | input | 32 | Physical address of the current process's directory table |
| miss_valid | input | 1 | Translation-buffer miss request |
| miss_vaddr | input | 32 | Virtual address that missed |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 32 | Physical byte address of the entry to read |
| mem_resp_valid | input | 1 | Read data is valid |
| mem_resp_data | input | 32 | Table entry read from memory |
| refill_valid | output | 1 | One-cycle translation result |
| refill_vpn | output | 20 | Virtual page number of the translation |
| refill_ppn | output | 20 | Physical page number |
| refill_perm | output | 3 | Permission bits from the leaf entry |
| fault_valid | output | 1 | Page fault being reported |
| fault_level | output | 1 | 0: directory entry unusable, 1: leaf entry unusable |
| fault_vaddr | output | 32 | Virtual address that faulted |
| fault_ack | input | 1 | Software has taken the fault |

## Verification
The hardest cases to reach from the ports are those where the outside world acts while the walker is mid-walk. In these cases a second miss, a new root pointer, late memory grants or stray responses arrive while a read is outstanding, and none of them may disturb the captured walk. The stimulus reaches them in two ways. A memory model with configurable latency grants only every third cycle, which stretches each wait state. On one walk the bench also holds a different miss and an inverted root pointer on the inputs for the whole walk. Separate idle phases inject responses and acknowledges with no walk running. Invalid and non-resident entries are placed at each level so that both fault levels are produced.

// File: rtl/pgwalk_pkg.sv
`timescale 1ns/1ps
package pgwalk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD1   = 3'd1,
    ST_WT1   = 3'd2,
    ST_RD2   = 3'd3,
    ST_WT2   = 3'd4,
    ST_DONE  = 3'd5,
    ST_FAULT = 3'd6
  } walk_state_t;

  typedef enum logic {
    LVL_DIR  = 1'b0,
    LVL_LEAF = 1'b1
  } walk_level_t;
endpackage

// File: rtl/pgwalk_addr_gen.sv
`timescale 1ns/1ps
module pgwalk_addr_gen
  import pgwalk_pkg::*;
#(
  parameter int PA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int IDX_W     = 10,
  parameter int PTE_BYTES = 4
) (
  input  walk_level_t            level,
  input  logic [PA_W-OFF_W-1:0]  root_ppn,
  input  logic [PA_W-OFF_W-1:0]  table_ppn,
  input  logic [IDX_W-1:0]       idx_dir,
  input  logic [IDX_W-1:0]       idx_leaf,
  output logic [PA_W-1:0]        entry_addr
);
  localparam int PPN_W = PA_W - OFF_W;
  localparam int SHIFT = $clog2(PTE_BYTES);

  // byte address of slot idx in the table starting at page base_ppn
  function automatic logic [PA_W-1:0] slot_addr(input logic [PPN_W-1:0] base_ppn,
                                                input logic [IDX_W-1:0] idx);
    logic [PA_W-1:0] base_b;
    logic [PA_W-1:0] off_b;
    base_b = {base_ppn, {OFF_W{1'b0}}};
    off_b  = {{(PA_W-IDX_W){1'b0}}, idx} << SHIFT;
    return base_b + off_b;
  endfunction

  logic [PPN_W-1:0] sel_base;
  logic [IDX_W-1:0] sel_idx;

  always_comb begin
    if (level == LVL_DIR) begin
      sel_base = root_ppn;
      sel_idx  = idx_dir;
    end else begin
      sel_base = table_ppn;
      sel_idx  = idx_leaf;
    end
    entry_addr = slot_addr(sel_base, sel_idx);
  end
endmodule

// File: rtl/pgwalk_entry_chk.sv
`timescale 1ns/1ps
module pgwalk_entry_chk #(
  parameter int PA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int PERM_W = 3
) (
  input  logic [PA_W-1:0]        entry,
  output logic                   present,
  output logic [PA_W-OFF_W-1:0]  ppn,
  output logic [PERM_W-1:0]      perm
);
  localparam int PPN_W    = PA_W - OFF_W;
  localparam int VALID_B  = 0;
  localparam int RESID_B  = 1;
  localparam int PERM_LSB = 2;

  function automatic logic usable(input logic [PA_W-1:0] e);
    return e[VALID_B] & e[RESID_B];
  endfunction

  logic unused_entry_bits;

  assign present           = usable(entry);
  assign ppn               = entry[OFF_W +: PPN_W];
  assign perm              = entry[PERM_LSB +: PERM_W];
  assign unused_entry_bits = ^entry;
endmodule

// File: rtl/pgwalk_fsm.sv
`timescale 1ns/1ps
module pgwalk_fsm
  import pgwalk_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 32,
  parameter int PERM_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      miss_valid,
  input  logic [2*IDX_W+OFF_W-1:0]  miss_vaddr,
  input  logic [PA_W-1:0]           root_ptr,
  input  logic                      mem_req_ready,
  input  logic                      mem_resp_valid,
  input  logic [PA_W-1:0]           req_addr,
  input  logic                      ent_present,
  input  logic [PA_W-OFF_W-1:0]     ent_ppn,
  input  logic [PERM_W-1:0]         ent_perm,
  input  logic                      fault_ack,
  output walk_level_t               walk_level,
  output logic [PA_W-OFF_W-1:0]     root_ppn,
  output logic [PA_W-OFF_W-1:0]     table_ppn,
  output logic [IDX_W-1:0]          idx_dir,
  output logic [IDX_W-1:0]          idx_leaf,
  output logic                      busy,
  output logic                      mem_req_valid,
  output logic                      refill_valid,
  output logic [2*IDX_W-1:0]        refill_vpn,
  output logic [PA_W-OFF_W-1:0]     refill_ppn,
  output logic [PERM_W-1:0]         refill_perm,
  output logic                      fault_valid,
  output logic                      fault_level,
  output logic [2*IDX_W+OFF_W-1:0]  fault_vaddr
);
  localparam int VA_W  = 2*IDX_W + OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  walk_state_t       state;
  logic [VA_W-1:0]   va_q;
  logic [PPN_W-1:0]  root_q;
  logic [PPN_W-1:0]  next_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [PERM_W-1:0] perm_q;
  walk_level_t       flvl_q;
  logic              unused_root_low;

  // named internal events
  logic accept_evt;
  logic req_fire;
  logic dir_take;
  logic leaf_take;
  logic ack_take;

  assign accept_evt = (state == ST_IDLE) && miss_valid;
  assign req_fire   = mem_req_valid && mem_req_ready;
  assign dir_take   = (state == ST_WT1) && mem_resp_valid;
  assign leaf_take  = (state == ST_WT2) && mem_resp_valid;
  assign ack_take   = (state == ST_FAULT) && fault_ack;

  assign unused_root_low = ^root_ptr[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      va_q   <= '0;
      root_q <= '0;
      next_q <= '0;
      ppn_q  <= '0;
      perm_q <= '0;
      flvl_q <= LVL_DIR;
    end else begin
      unique case (state)
        ST_IDLE: if (accept_evt) begin
          va_q   <= miss_vaddr;
          root_q <= root_ptr[PA_W-1:OFF_W];
          state  <= ST_RD1;
        end
        ST_RD1: if (req_fire) state <= ST_WT1;
        ST_WT1: if (dir_take) begin
          if (ent_present) begin
            next_q <= ent_ppn;
            state  <= ST_RD2;
          end else begin
            flvl_q <= LVL_DIR;
            state  <= ST_FAULT;
          end
        end
        ST_RD2: if (req_fire) state <= ST_WT2;
        ST_WT2: if (leaf_take) begin
          if (ent_present) begin
            ppn_q  <= ent_ppn;
            perm_q <= ent_perm;
            state  <= ST_DONE;
          end else begin
            flvl_q <= LVL_LEAF;
            state  <= ST_FAULT;
          end
        end
        ST_DONE:  state <= ST_IDLE;
        ST_FAULT: if (ack_take) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign walk_level    = (state == ST_RD2) ? LVL_LEAF : LVL_DIR;
  assign root_ppn      = root_q;
  assign table_ppn     = next_q;
  assign idx_dir       = va_q[VA_W-1 -: IDX_W];
  assign idx_leaf      = va_q[OFF_W +: IDX_W];
  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_RD1) || (state == ST_RD2);
  assign refill_valid  = (state == ST_DONE);
  assign refill_vpn    = va_q[VA_W-1:OFF_W];
  assign refill_ppn    = ppn_q;
  assign refill_perm   = perm_q;
  assign fault_valid   = (state == ST_FAULT);
  assign fault_level   = (flvl_q == LVL_LEAF);
  assign fault_vaddr   = va_q;

  // R2: an idle walker with no miss stays idle
  assert_idle_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !miss_valid) |=> !busy);
  // R2: an accepted miss makes the walker busy
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy);
  // R3: a pending request is held steady until granted
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(req_addr)));
  // R4: a usable directory entry leads straight to the leaf request
  assert_leaf_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_take && ent_present) |=> mem_req_valid);
  // R5: refill is a single-cycle pulse followed by idle
  assert_refill_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |=> (!refill_valid && !busy));
  // R6: an unusable directory entry reports a level-0 fault
  assert_dir_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_take && !ent_present) |=> (fault_valid && !fault_level));
  // R6: fault report holds until acknowledged
  assert_fault_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !fault_ack) |=> (fault_valid && $stable(fault_vaddr) && $stable(fault_level)));
  // R7: no request while idle, never refill and fault together
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);
  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(refill_valid && fault_valid));
endmodule

// File: rtl/pgwalk_top.sv
`timescale 1ns/1ps
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 32,
  parameter int PERM_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PA_W-1:0]           root_ptr,
  input  logic                      miss_valid,
  input  logic [2*IDX_W+OFF_W-1:0]  miss_vaddr,
  output logic                      busy,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [PA_W-1:0]           mem_req_addr,
  input  logic                      mem_resp_valid,
  input  logic [PA_W-1:0]           mem_resp_data,
  output logic                      refill_valid,
  output logic [2*IDX_W-1:0]        refill_vpn,
  output logic [PA_W-OFF_W-1:0]     refill_ppn,
  output logic [PERM_W-1:0]         refill_perm,
  output logic                      fault_valid,
  output logic                      fault_level,
  output logic [2*IDX_W+OFF_W-1:0]  fault_vaddr,
  input  logic                      fault_ack
);
  localparam int PPN_W     = PA_W - OFF_W;
  localparam int PTE_BYTES = PA_W / 8;

  walk_level_t       walk_level;
  logic [PPN_W-1:0]  root_ppn;
  logic [PPN_W-1:0]  table_ppn;
  logic [IDX_W-1:0]  idx_dir;
  logic [IDX_W-1:0]  idx_leaf;
  logic              ent_present;
  logic [PPN_W-1:0]  ent_ppn;
  logic [PERM_W-1:0] ent_perm;

  pgwalk_addr_gen #(
    .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_BYTES(PTE_BYTES)
  ) u_addr (
    .level(walk_level), .root_ppn(root_ppn), .table_ppn(table_ppn),
    .idx_dir(idx_dir), .idx_leaf(idx_leaf), .entry_addr(mem_req_addr)
  );

  pgwalk_entry_chk #(
    .PA_W(PA_W), .OFF_W(OFF_W), .PERM_W(PERM_W)
  ) u_chk (
    .entry(mem_resp_data), .present(ent_present), .ppn(ent_ppn), .perm(ent_perm)
  );

  pgwalk_fsm #(
    .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W), .PERM_W(PERM_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .root_ptr(root_ptr),
    .mem_req_ready(mem_req_ready), .mem_resp_valid(mem_resp_valid),
    .req_addr(mem_req_addr),
    .ent_present(ent_present), .ent_ppn(ent_ppn), .ent_perm(ent_perm),
    .fault_ack(fault_ack),
    .walk_level(walk_level), .root_ppn(root_ppn), .table_ppn(table_ppn),
    .idx_dir(idx_dir), .idx_leaf(idx_leaf),
    .busy(busy), .mem_req_valid(mem_req_valid),
    .refill_valid(refill_valid), .refill_vpn(refill_vpn),
    .refill_ppn(refill_ppn), .refill_perm(refill_perm),
    .fault_valid(fault_valid), .fault_level(fault_level), .fault_vaddr(fault_vaddr)
  );
endmodule

// File: tb/pgwalk_top_test.sv
`timescale 1ns/1ps
module pgwalk_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] root_ptr;
  logic        miss_valid;
  logic [31:0] miss_vaddr;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_resp_valid;
  logic [31:0] mem_resp_data;
  logic        refill_valid;
  logic [19:0] refill_vpn;
  logic [19:0] refill_ppn;
  logic [2:0]  refill_perm;
  logic        fault_valid;
  logic        fault_level;
  logic [31:0] fault_vaddr;
  logic        fault_ack;

  always #5 clk = ~clk;

  pgwalk_top uut (
    .clk(clk), .rst_n(rst_n), .root_ptr(root_ptr),
    .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data), .refill_valid(refill_valid),
    .refill_vpn(refill_vpn), .refill_ppn(refill_ppn), .refill_perm(refill_perm),
    .fault_valid(fault_valid), .fault_level(fault_level),
    .fault_vaddr(fault_vaddr), .fault_ack(fault_ack)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // bench memory (unset slots read as 0, i.e. not valid)
  logic [31:0] mem [logic [31:0]];

  // reference model state: 0 idle,1 read dir,2 wait dir,3 read leaf,4 wait leaf,5 done,6 fault
  int          ms = 0;
  logic [31:0] m_va, m_root, m_e, m_paddr;
  logic [19:0] m_next, m_ppn;
  logic [2:0]  m_perm;
  logic        m_flvl;
  int          pend = 0, cnt = 0;
  int          lat = 0, ready_mode = 0;
  logic        spur = 1'b0;

  // captured outcome from the ports
  int          cap_kind;
  logic [19:0] cap_ppn, cap_vpn;
  logic [2:0]  cap_perm;
  logic        cap_lvl;
  logic [31:0] cap_va;
  int          nreads;
  logic [31:0] rd_addr [2];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] slot(input logic [31:0] base_bytes, input int idx);
    return (base_bytes & 32'hFFFF_F000) + 32'(idx * 4);
  endfunction

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] pte(input logic [19:0] pg, input logic [2:0] pm,
                                      input logic v, input logic r);
    return {pg, 7'b0, pm, r, v};
  endfunction

  function automatic logic [31:0] model_addr();
    if (ms == 1) return slot(m_root, int'(m_va >> 22));
    return slot({m_next, 12'h000}, int'((m_va >> 12) & 32'h3FF));
  endfunction

  always @(negedge clk) begin
    cyc++;
    // step the model with the inputs held across the last rising edge
    if (!rst_n) begin
      ms = 0; pend = 0;
    end else begin
      case (ms)
        0: if (miss_valid) begin m_va = miss_vaddr; m_root = root_ptr; ms = 1; end
        1, 3: if (mem_req_ready) begin
          m_paddr = model_addr(); pend = 1; cnt = lat; ms = ms + 1;
        end
        2: if (mem_resp_valid) begin
          m_e = mem_resp_data;
          if ((m_e & 32'h3) == 32'h3) begin m_next = m_e[31:12]; ms = 3; end
          else begin m_flvl = 1'b0; ms = 6; end
        end
        4: if (mem_resp_valid) begin
          m_e = mem_resp_data;
          if ((m_e & 32'h3) == 32'h3) begin m_ppn = m_e[31:12]; m_perm = m_e[4:2]; ms = 5; end
          else begin m_flvl = 1'b1; ms = 6; end
        end
        5: ms = 0;
        6: if (fault_ack) ms = 0;
        default: ms = 0;
      endcase
    end
    // compare every output with the model
    check("R2 busy", {31'b0, busy}, {31'b0, ms != 0});
    check("R7 mem_req_valid", {31'b0, mem_req_valid}, {31'b0, ms == 1 || ms == 3});
    if (ms == 1) check("R3 dir address", mem_req_addr, model_addr());
    if (ms == 3) check("R4 leaf address", mem_req_addr, model_addr());
    check("R5 refill_valid", {31'b0, refill_valid}, {31'b0, ms == 5});
    if (ms == 5) begin
      check("R5 refill_ppn", {12'b0, refill_ppn}, {12'b0, m_ppn});
      check("R5 refill_perm", {29'b0, refill_perm}, {29'b0, m_perm});
      check("R5 refill_vpn", {12'b0, refill_vpn}, {12'b0, m_va[31:12]});
    end
    check("R6 fault_valid", {31'b0, fault_valid}, {31'b0, ms == 6});
    if (ms == 6) begin
      check("R6 fault_level", {31'b0, fault_level}, {31'b0, m_flvl});
      check("R6 fault_vaddr", fault_vaddr, m_va);
    end
    // capture outcome
    if (refill_valid) begin
      cap_kind = 1; cap_ppn = refill_ppn; cap_perm = refill_perm; cap_vpn = refill_vpn;
    end
    if (fault_valid) begin
      cap_kind = 2; cap_lvl = fault_level; cap_va = fault_vaddr;
    end
    // memory side: ready, responses
    mem_req_ready = (ready_mode == 0) ? 1'b1 : (cyc % 3 == 0);
    if (pend != 0) begin
      if (cnt == 0) begin
        mem_resp_valid = 1'b1; mem_resp_data = rd_mem(m_paddr); pend = 0;
      end else begin
        cnt--; mem_resp_valid = 1'b0; mem_resp_data = 32'hDEAD_BEEF;
      end
    end else if (spur) begin
      mem_resp_valid = 1'b1; mem_resp_data = pte(20'hFFFFF, 3'b111, 1'b1, 1'b1);
    end else begin
      mem_resp_valid = 1'b0; mem_resp_data = 32'h0;
    end
    // count reads that the next rising edge will grant
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (nreads < 2) rd_addr[nreads] = mem_req_addr;
      nreads++;
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic run_walk(input logic [31:0] va, input logic [31:0] root,
                          input int latency, input int rmode, input int ackdel,
                          input bit noise);
    @(negedge clk); #2;
    lat = latency; ready_mode = rmode; cap_kind = 0; nreads = 0;
    root_ptr = root; miss_vaddr = va; miss_valid = 1'b1;
    @(negedge clk); #2;
    miss_valid = 1'b0;
    if (noise) begin root_ptr = ~root; miss_vaddr = ~va; end
    forever begin
      @(negedge clk); #2;
      if (noise) miss_valid = (ms >= 1 && ms <= 4);
      if (ms == 6) begin
        repeat (ackdel) @(negedge clk);
        #2 fault_ack = 1'b1;
        @(negedge clk); #2 fault_ack = 1'b0;
      end
      if (ms == 0) break;
    end
    miss_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; root_ptr = 32'h0; miss_valid = 1'b0; miss_vaddr = 32'h0;
    fault_ack = 1'b0; mem_req_ready = 1'b1; mem_resp_valid = 1'b0; mem_resp_data = 32'h0;
    nreads = 0; cap_kind = 0;
    // tables
    mem[32'h0001_0004] = pte(20'h00020, 3'b000, 1'b1, 1'b1);
    mem[32'h0002_000C] = pte(20'h12345, 3'b101, 1'b1, 1'b1);
    mem[32'h0003_0FFC] = pte(20'h00040, 3'b000, 1'b1, 1'b1);
    mem[32'h0004_0FFC] = pte(20'hABCDE, 3'b111, 1'b1, 1'b1);
    mem[32'h0001_0014] = pte(20'h00020, 3'b000, 1'b1, 1'b0);
    mem[32'h0002_0014] = pte(20'h55555, 3'b111, 1'b1, 1'b0);
    mem[32'h0001_000C] = pte(20'h00020, 3'b000, 1'b1, 1'b1);
    mem[32'h0002_0018] = pte(20'h00777, 3'b010, 1'b1, 1'b1);

    repeat (3) @(negedge clk);
    #1;
    check("R1 busy in reset", {31'b0, busy}, 32'h0);
    check("R1 req in reset", {31'b0, mem_req_valid}, 32'h0);
    check("R1 refill in reset", {31'b0, refill_valid}, 32'h0);
    check("R1 fault in reset", {31'b0, fault_valid}, 32'h0);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 idle after reset", {29'b0, busy, mem_req_valid, fault_valid}, 32'h0);

    // basic success
    run_walk(32'h0040_3ABC, 32'h0001_0000, 0, 0, 0, 1'b0);
    check("R5 kind", 32'(cap_kind), 32'd1);
    check("R5 ppn", {12'b0, cap_ppn}, 32'h12345);
    check("R5 perm", {29'b0, cap_perm}, 32'd5);
    check("R5 vpn", {12'b0, cap_vpn}, 32'h00403);
    check("R3 first address", rd_addr[0], 32'h0001_0004);
    check("R4 second address", rd_addr[1], 32'h0002_000C);
    check("R8 reads on success", 32'(nreads), 32'd2);

    // top indices, slow grants, long latency
    run_walk(32'hFFFF_FFFF, 32'h0003_0ABC, 3, 1, 0, 1'b0);
    check("R5 ppn top index", {12'b0, cap_ppn}, 32'hABCDE);
    check("R5 perm top index", {29'b0, cap_perm}, 32'd7);
    check("R3 first address top index", rd_addr[0], 32'h0003_0FFC);
    check("R4 second address top index", rd_addr[1], 32'h0004_0FFC);

    // directory entry not valid
    run_walk(32'h0080_0123, 32'h0001_0000, 1, 0, 2, 1'b0);
    check("R6 dir invalid kind", 32'(cap_kind), 32'd2);
    check("R6 dir invalid level", {31'b0, cap_lvl}, 32'd0);
    check("R6 dir invalid vaddr", cap_va, 32'h0080_0123);
    check("R8 reads on dir fault", 32'(nreads), 32'd1);

    // directory entry valid but not resident
    run_walk(32'h0140_0000, 32'h0001_0000, 0, 0, 0, 1'b0);
    check("R6 dir nonresident level", {31'b0, cap_lvl}, 32'd0);
    check("R8 reads dir nonresident", 32'(nreads), 32'd1);

    // leaf entry missing, ack held off
    run_walk(32'h0040_4FFF, 32'h0001_0000, 2, 1, 5, 1'b0);
    check("R6 leaf invalid kind", 32'(cap_kind), 32'd2);
    check("R6 leaf invalid level", {31'b0, cap_lvl}, 32'd1);
    check("R6 leaf invalid vaddr", cap_va, 32'h0040_4FFF);
    check("R8 reads on leaf fault", 32'(nreads), 32'd2);

    // leaf entry valid but not resident
    run_walk(32'h0040_5000, 32'h0001_0000, 0, 0, 1, 1'b0);
    check("R6 leaf nonresident level", {31'b0, cap_lvl}, 32'd1);

    // inputs disturbed during walk: other miss and new root must be ignored
    run_walk(32'h0040_6010, 32'h0001_0000, 2, 1, 0, 1'b1);
    check("R2 captured walk kind", 32'(cap_kind), 32'd1);
    check("R2 captured vpn", {12'b0, cap_vpn}, 32'h00406);
    check("R2 captured root ppn", {12'b0, cap_ppn}, 32'h00777);
    check("R2 captured root address", rd_addr[0], 32'h0001_0004);

    // idle: stray responses and acks have no effect
    @(negedge clk); #2 spur = 1'b1; fault_ack = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R7 busy after stray inputs", {31'b0, busy}, 32'h0);
    check("R7 no fault after stray inputs", {31'b0, fault_valid}, 32'h0);
    check("R7 no refill after stray inputs", {31'b0, refill_valid}, 32'h0);
    #1 spur = 1'b0; fault_ack = 1'b0;

    // walker still usable afterwards
    run_walk(32'h0040_3000, 32'h0001_0000, 0, 0, 0, 1'b0);
    check("R5 ppn after stray inputs", {12'b0, cap_ppn}, 32'h12345);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule